// File: doc/BRIEF.md
# Bitfield Extract and Insert Unit

This block executes two 64-bit bitfield operations carried in a 32-bit instruction word. The signed extract operation pulls a field out of the source operand, moves it down to bit 0 and copies its top bit into every bit above it. The clear-and-insert operation takes the low bits of the source operand and places them at a chosen bit position in an all-zero result. The field length is the 5-bit length-minus-one value plus one, and the start position is a 5-bit value that a separate one-bit control lifts by 32 so that fields can live in the upper half.

A pipeline hands the block an instruction word, the source operand value and a valid strobe. One clock later the block returns the result, the destination register index taken from the instruction, a write-enable and an illegal flag. Register file access and all other opcodes belong to the surrounding pipeline.

Top module: `bitfield_unit`

## Requirements
- R1: The word is legal only when bits [31:26] equal 011100 and bits [5:1] equal 11101 (signed extract) or 11001 (clear-and-insert); any other valid word raises `illegal` and produces no write.
- R2: The effective bit position is the 5-bit value in bits [10:6], plus 32 when bit 0 is 1.
- R3: The field length is the value in bits [15:11] plus one, so 0 gives a 1-bit field and 31 gives a 32-bit field.
- R4: Signed extract returns the field right-aligned at bit 0, with every bit above the field equal to the field's top bit.
- R5: For signed extract, field bits that would lie above source bit 63 read as zero, and that zero also serves as the sign when it is the field's top bit.
- R6: Clear-and-insert places the low field-length source bits at the effective position; every other result bit is zero and bits that would pass bit 63 are dropped.
- R7: A legal word whose destination index (bits [20:16]) is 0 produces no write and does not raise `illegal`.
- R8: Outputs appear exactly one clock after the valid input, `dst_idx` carries bits [20:16] of that word, and back-to-back valid inputs each produce their own result.
- R9: Synchronous active-high reset clears `out_valid`, `wr_en` and `illegal`.
- R10: A cycle without `in_valid` produces no `out_valid`, `wr_en` or `illegal` in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction and operand are present |
| instr | input | 32 | Instruction word |
| src_val | input | 64 | Source operand value |
| out_valid | output | 1 | Registered copy of in_valid |
| wr_en | output | 1 | Write the result to dst_idx |
| dst_idx | output | 5 | Destination register index |
| result | output | 64 | Operation result |
| illegal | output | 1 | Valid word with an unsupported encoding |

## Verification
On every cycle the assertions check the handshake timing: a valid input is followed by out_valid, an idle cycle by silence, and write and illegal are never raised together. They also check two datapath traits on every legal operation: a set field top bit forces result bit 63 high after an extract, and an insert away from position 0 leaves bit 0 clear. The exact result values only show up in the bench's scenarios. These include the upper-half offset, the full 32-bit and 1-bit lengths, fields that run past bit 63, a zero destination, malformed words, back-to-back issue and reset during a valid cycle.

// File: rtl/bf_pkg.sv
package bf_pkg;

    localparam int DATA_W  = 64;
    localparam int INSTR_W = 32;
    localparam int FLD_W   = 5;
    localparam int POS_W   = $clog2(DATA_W);
    localparam int HALF_W  = DATA_W / 2;

    localparam logic [5:0]       MAJOR_OP    = 6'b011100;
    localparam logic [FLD_W-1:0] SUB_EXTRACT = 5'b11101;
    localparam logic [FLD_W-1:0] SUB_INSERT  = 5'b11001;

    typedef enum logic [1:0] {
        BF_NONE    = 2'd0,
        BF_EXTRACT = 2'd1,
        BF_INSERT  = 2'd2
    } bf_kind_e;

    typedef struct packed {
        bf_kind_e         kind;
        logic             legal;
        logic [FLD_W-1:0] rt;
        logic [FLD_W-1:0] lenm1;
        logic [POS_W-1:0] pos;
    } bf_ctl_t;

    // Ones in bits 0..lenm1, zeros above.
    function automatic logic [DATA_W-1:0] low_mask(input logic [FLD_W-1:0] lenm1);
        logic [DATA_W-1:0] m;
        for (int i = 0; i < DATA_W; i++) begin
            m[i] = (32'(i) <= 32'(lenm1));
        end
        return m;
    endfunction

endpackage

// File: rtl/bf_decode.sv
module bf_decode
    import bf_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output bf_ctl_t            ctl
);
    logic [5:0]       major;
    logic [FLD_W-1:0] sub;
    logic             upper;
    logic [FLD_W-1:0] p_low;

    assign major = instr[31:26];
    assign sub   = instr[5:1];
    assign upper = instr[0];
    assign p_low = instr[10:6];

    always_comb begin
        ctl.rt    = instr[20:16];
        ctl.lenm1 = instr[15:11];
        ctl.pos   = POS_W'(p_low) + (upper ? POS_W'(HALF_W) : '0);
        ctl.kind  = BF_NONE;
        if (major == MAJOR_OP) begin
            if (sub == SUB_EXTRACT)     ctl.kind = BF_EXTRACT;
            else if (sub == SUB_INSERT) ctl.kind = BF_INSERT;
        end
        ctl.legal = (ctl.kind != BF_NONE);
    end

    // rs index in [25:21] is resolved by the register file outside this block
    logic [4:0] rs_unused;
    assign rs_unused = instr[25:21];
endmodule

// File: rtl/bf_extract.sv
module bf_extract
    import bf_pkg::*;
(
    input  logic [DATA_W-1:0] src,
    input  logic [POS_W-1:0]  pos,
    input  logic [FLD_W-1:0]  lenm1,
    output logic [DATA_W-1:0] res
);
    logic [DATA_W-1:0] aligned;
    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] field;
    logic              sign;

    assign aligned = src >> pos;
    assign mask    = low_mask(lenm1);
    assign field   = aligned & mask;
    assign sign    = field[lenm1];

    for (genvar i = 0; i < DATA_W; i++) begin : g_fill
        assign res[i] = mask[i] ? field[i] : sign;
    end
endmodule

// File: rtl/bf_insert.sv
module bf_insert
    import bf_pkg::*;
(
    input  logic [DATA_W-1:0] src,
    input  logic [POS_W-1:0]  pos,
    input  logic [FLD_W-1:0]  lenm1,
    output logic [DATA_W-1:0] res
);
    logic [DATA_W-1:0] trimmed;

    assign trimmed = src & low_mask(lenm1);
    assign res     = trimmed << pos;
endmodule

// File: rtl/bitfield_unit.sv
module bitfield_unit
    import bf_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [INSTR_W-1:0]  instr,
    input  logic [DATA_W-1:0]   src_val,
    output logic                out_valid,
    output logic                wr_en,
    output logic [FLD_W-1:0]    dst_idx,
    output logic [DATA_W-1:0]   result,
    output logic                illegal
);
    bf_ctl_t           ctl;
    logic [DATA_W-1:0] ext_res;
    logic [DATA_W-1:0] ins_res;
    logic [DATA_W-1:0] next_res;

    bf_decode u_dec (
        .instr (instr),
        .ctl   (ctl)
    );

    bf_extract u_ext (
        .src   (src_val),
        .pos   (ctl.pos),
        .lenm1 (ctl.lenm1),
        .res   (ext_res)
    );

    bf_insert u_ins (
        .src   (src_val),
        .pos   (ctl.pos),
        .lenm1 (ctl.lenm1),
        .res   (ins_res)
    );

    always_comb begin
        unique case (ctl.kind)
            BF_EXTRACT: next_res = ext_res;
            BF_INSERT:  next_res = ins_res;
            default:    next_res = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            wr_en     <= 1'b0;
            illegal   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            wr_en     <= in_valid && ctl.legal && (ctl.rt != '0);
            illegal   <= in_valid && !ctl.legal;
        end
        dst_idx <= ctl.rt;
        result  <= next_res;
    end

    // Top source bit of the requested field, zero when it lies past bit 63
    logic [POS_W:0] top_idx;
    logic           src_sign;
    always_comb begin
        top_idx  = (POS_W+1)'(ctl.pos) + (POS_W+1)'(ctl.lenm1);
        src_sign = (top_idx < (POS_W+1)'(DATA_W)) ? src_val[top_idx[POS_W-1:0]] : 1'b0;
    end

    // R8
    valid_follows_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !wr_en && !illegal));

    // R1
    write_or_illegal_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wr_en, illegal}));

    // R4
    sign_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && ctl.kind == BF_EXTRACT && src_sign) |=> result[DATA_W-1]);

    // R6
    insert_low_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && ctl.kind == BF_INSERT && ctl.pos != '0) |=> !result[0]);
endmodule

// File: tb/bitfield_unit_test.sv
module bitfield_unit_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [31:0] instr;
    logic [63:0] src_val;
    logic        out_valid;
    logic        wr_en;
    logic [4:0]  dst_idx;
    logic [63:0] result;
    logic        illegal;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    bitfield_unit uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
        .src_val(src_val), .out_valid(out_valid), .wr_en(wr_en),
        .dst_idx(dst_idx), .result(result), .illegal(illegal)
    );

    localparam int NV = 12;
    // word layout: {major, rs, rt, lenm1, p, sub, upper}
    localparam logic [31:0] T_INSTR [NV] = '{
        {6'b011100, 5'd1, 5'd5,  5'd3,  5'd8,  5'b11101, 1'b0},
        {6'b011100, 5'd1, 5'd6,  5'd3,  5'd8,  5'b11101, 1'b0},
        {6'b011100, 5'd2, 5'd7,  5'd0,  5'd31, 5'b11101, 1'b1},
        {6'b011100, 5'd2, 5'd8,  5'd15, 5'd24, 5'b11101, 1'b1},
        {6'b011100, 5'd3, 5'd9,  5'd31, 5'd0,  5'b11101, 1'b0},
        {6'b011100, 5'd3, 5'd10, 5'd7,  5'd4,  5'b11001, 1'b0},
        {6'b011100, 5'd4, 5'd11, 5'd15, 5'd0,  5'b11001, 1'b1},
        {6'b011100, 5'd4, 5'd12, 5'd15, 5'd24, 5'b11001, 1'b1},
        {6'b011100, 5'd5, 5'd31, 5'd0,  5'd0,  5'b11001, 1'b0},
        {6'b011100, 5'd5, 5'd0,  5'd3,  5'd8,  5'b11101, 1'b0},
        {6'b011100, 5'd6, 5'd13, 5'd3,  5'd8,  5'b10101, 1'b0},
        {6'b000000, 5'd6, 5'd14, 5'd3,  5'd8,  5'b11101, 1'b0}
    };
    localparam logic [63:0] T_SRC [NV] = '{
        64'h0000_0000_0000_0F00, 64'h0000_0000_0000_0700,
        64'h8000_0000_0000_0000, 64'hFFFF_0000_0000_0000,
        64'h1234_5678_9ABC_DEF0, 64'hFFFF_FFFF_FFFF_FFFF,
        64'h0000_0000_0000_ABCD, 64'h0000_0000_0000_FFFF,
        64'h0000_0000_0000_0003, 64'h0000_0000_0000_0F00,
        64'h0000_0000_0000_0F00, 64'h0000_0000_0000_0F00
    };
    localparam logic [63:0] T_RES [NV] = '{
        64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0007,
        64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_00FF,
        64'hFFFF_FFFF_9ABC_DEF0, 64'h0000_0000_0000_0FF0,
        64'h0000_ABCD_0000_0000, 64'hFF00_0000_0000_0000,
        64'h0000_0000_0000_0001, 64'h0,
        64'h0, 64'h0
    };
    localparam logic T_WR  [NV] = '{1,1,1,1,1,1,1,1,1,0,0,0};
    localparam logic T_ILL [NV] = '{0,0,0,0,0,0,0,0,0,0,1,1};
    localparam string T_TAG [NV] = '{
        "R4", "R4", "R2", "R5", "R3", "R6", "R2", "R6", "R3", "R7", "R1", "R1"
    };

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic issue(input int k);
        instr    = T_INSTR[k];
        src_val  = T_SRC[k];
        in_valid = 1'b1;
    endtask

    task automatic check_vec(input int k);
        check(out_valid === 1'b1, {T_TAG[k], " out_valid"}, 64'(out_valid), 64'd1);
        check(wr_en === T_WR[k], {T_TAG[k], " wr_en"}, 64'(wr_en), 64'(T_WR[k]));
        check(illegal === T_ILL[k], {T_TAG[k], " illegal"}, 64'(illegal), 64'(T_ILL[k]));
        if (T_WR[k]) begin
            check(result === T_RES[k], {T_TAG[k], " result"}, result, T_RES[k]);
            check(dst_idx === T_INSTR[k][20:16], "R8 dst_idx", 64'(dst_idx),
                  64'(T_INSTR[k][20:16]));
        end
    endtask

    initial begin
        rst = 1'b1; in_valid = 1'b0; instr = '0; src_val = '0;
        repeat (3) @(negedge clk);
        // R9: reset state
        check(!out_valid && !wr_en && !illegal, "R9 reset state",
              64'({out_valid, wr_en, illegal}), 64'd0);
        rst = 1'b0;

        for (int k = 0; k < NV; k++) begin
            issue(k);
            @(negedge clk);
            in_valid = 1'b0;
            check_vec(k);
        end

        // R10: legal word present but no valid strobe
        instr = T_INSTR[0]; src_val = T_SRC[0]; in_valid = 1'b0;
        @(negedge clk);
        check(!out_valid && !wr_en && !illegal, "R10 idle",
              64'({out_valid, wr_en, illegal}), 64'd0);

        // R8: back-to-back issue
        issue(5);
        @(negedge clk);
        check_vec(5);
        issue(3);
        @(negedge clk);
        check_vec(3);
        issue(10);
        @(negedge clk);
        in_valid = 1'b0;
        check_vec(10);
        @(negedge clk);
        check(!out_valid, "R8 valid drops", 64'(out_valid), 64'd0);

        // R9: reset wins over a valid input
        issue(0);
        rst = 1'b1;
        @(negedge clk);
        check(!out_valid && !wr_en && !illegal, "R9 reset during valid",
              64'({out_valid, wr_en, illegal}), 64'd0);
        issue(11);
        @(negedge clk);
        check(!illegal, "R9 illegal held clear", 64'(illegal), 64'd0);
        rst = 1'b0; in_valid = 1'b0;
        @(negedge clk);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule